// File: doc/BRIEF.md
# Class-Partitioned Way Allocator for a Shared Cache Set

This block makes the replacement decision for one set of a set-associative shared cache in which the ways are divided among four classes of service. Every request carries a 2-bit class tag. Each class owns a capacity mask with one bit per way. When a read or write misses, that mask limits the ways the requester may fill. Lookups are never filtered by class: a read or write that matches a valid line hits in whatever way holds it. A flush that matches a valid line invalidates it in any way, with no class check. A line filled under one class therefore stays visible to every other class and can be flushed by every other class. Only the choice of which line to displace respects the partition.

The surrounding cache pipeline supplies the per-way tag-compare vector and the per-way valid bits of the addressed set. It also supplies the request kind and the requester's class. The block answers in the same cycle with a hit way, an invalidate way, a fill way, or a bypass flag. It keeps the set's tree pseudo-LRU state and the four class masks internally. Privileged software writes the masks through a one-cycle write port. The tag and data arrays apply the decisions and are not part of this block.

Top module: `cap_alloc_ctrl`

## Requirements
- R1: There are exactly four classes, selected by a 2-bit class tag, and each class has its own WAYS-bit capacity mask. After reset every mask is all ones, so every class may fill every way.
- R2: A mask write with `cfg_we` high changes only the mask of class `cfg_cos`. The new value applies from the access in the next cycle; an access in the same cycle as the write still sees the old mask.
- R3: A read (`req_kind`=0) or write (`req_kind`=1) whose `req_match & line_vld` is non-zero raises `hit`, and `hit_way` gives the lowest such way, whatever the requester's mask. A match on an invalid way is not a hit.
- R4: On a read or write miss, `fill` rises only when the requester's mask is non-zero, and `fill_way` always names a way whose mask bit is set.
- R5: On a miss, if any way that is enabled in the mask is invalid, `fill_way` is the lowest-index way among those.
- R6: On a miss where every enabled way is valid, the victim comes from a binary pseudo-LRU tree. The tree nodes are numbered as a heap: root 1, children 2n and 2n+1, leaf of way w at WAYS+w. From the root, the walk follows the node bit (0 means left, 1 means right) but takes the other child whenever the chosen subtree holds no enabled way. Every hit and every fill sets the bits along that way's path to point away from it. All tree bits are 0 after reset.
- R7: A read or write miss whose requester has an all-zero mask raises `no_alloc`, does not raise `fill`, and leaves the tree unchanged.
- R8: A flush (`req_kind`=2) whose `req_match & line_vld` is non-zero raises `inval`, with `inval_way` the lowest such way, for any class and any mask. A flush never updates the tree. A flush that matches nothing produces no output.
- R9: `hit`, `inval`, `fill` and `no_alloc` are never high together, and all four are low when `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Capacity mask write enable |
| cfg_cos | input | COS_W (2) | Class whose mask is written |
| cfg_mask | input | WAYS (16) | New capacity mask value |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 0 read, 1 write, 2 flush, 3 ignored |
| req_cos | input | COS_W (2) | Requester class |
| req_match | input | WAYS (16) | Per-way tag compare result |
| line_vld | input | WAYS (16) | Per-way valid bits of the set |
| hit | output | 1 | Read/write hit |
| hit_way | output | log2(WAYS) (4) | Lowest hitting way |
| inval | output | 1 | Flush matched a valid line |
| inval_way | output | log2(WAYS) (4) | Way to invalidate |
| fill | output | 1 | Miss allocates a way |
| fill_way | output | log2(WAYS) (4) | Way chosen for the fill |
| no_alloc | output | 1 | Miss bypasses the cache (empty mask) |

## Verification
The checker keeps its own copy of the four masks from the write port. On every cycle it confirms that a fill lands in an enabled way, and in an invalid one when one is available. It also confirms that a bypass happens only under an empty mask, that hit and invalidate ways really match valid lines, and that the four outcomes stay exclusive. Which way the pseudo-LRU tree picks, the one-cycle delay before a new mask takes effect, and hits and flushes that go through despite an empty mask can only be shown by the bench. The bench sweeps every mask against every valid pattern for every class in a four-way configuration and tracks the expected tree state itself.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FLUSH = 2'd2,
      ACC_NONE  = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/cap_prio_enc.sv
module cap_prio_enc #(
   parameter int N = 16
) (
   input  logic [N-1:0]         vec,
   output logic                 any,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IW = $clog2(N);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
      any = |vec;
   end
endmodule

// File: rtl/cap_mask_regs.sv
module cap_mask_regs #(
   parameter int WAYS  = 16,
   parameter int COS_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [COS_W-1:0] wr_cos,
   input  logic [WAYS-1:0]  wr_mask,
   input  logic [COS_W-1:0] rd_cos,
   output logic [WAYS-1:0]  rd_mask
);
   localparam int NCOS = 1 << COS_W;

   logic [WAYS-1:0] mask_q [NCOS];

   for (genvar c = 0; c < NCOS; c++) begin : g_cls
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_q[c] <= '1;
         end else if (wr_en && (wr_cos == COS_W'(c))) begin
            mask_q[c] <= wr_mask;
         end
      end
   end

   assign rd_mask = mask_q[rd_cos];
endmodule

// File: rtl/cap_plru.sv
module cap_plru #(
   parameter int WAYS = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [WAYS-1:0]         elig,
   output logic [$clog2(WAYS)-1:0] pick,
   input  logic                    touch_en,
   input  logic [$clog2(WAYS)-1:0] touch_way
);
   localparam int LVL = $clog2(WAYS);

   logic [WAYS-1:1]   tree_q;
   logic [WAYS-1:1]   tree_d;
   logic [2*WAYS-1:1] sub;
   logic [LVL:0]      nd;
   logic [LVL:0]      ch;
   logic [LVL:0]      up;

   // Subtree eligibility, then a walk that avoids empty subtrees.
   always_comb begin
      for (int w = 0; w < WAYS; w++) sub[WAYS+w] = elig[w];
      for (int n = WAYS - 1; n >= 1; n--) sub[n] = sub[2*n] | sub[2*n+1];
      nd = (LVL+1)'(1);
      ch = '0;
      for (int l = 0; l < LVL; l++) begin
         ch = {nd[LVL-1:0], tree_q[nd[LVL-1:0]]};
         if (!sub[ch]) ch[0] = ~ch[0];
         nd = ch;
      end
      pick = nd[LVL-1:0];
   end

   // Path update pointing every node away from the used way.
   always_comb begin
      tree_d = tree_q;
      up     = {1'b1, touch_way};
      if (touch_en) begin
         for (int l = 0; l < LVL; l++) begin
            tree_d[up[LVL:1]] = ~up[0];
            up = {1'b0, up[LVL:1]};
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tree_q <= '0;
      else        tree_q <= tree_d;
   end
endmodule

// File: rtl/cap_alloc_ctrl.sv
module cap_alloc_ctrl #(
   parameter int WAYS    = 16,
   parameter int COS_W   = 2,
   parameter bit PLRU_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [COS_W-1:0]        cfg_cos,
   input  logic [WAYS-1:0]         cfg_mask,
   input  logic                    req_valid,
   input  logic [1:0]              req_kind,
   input  logic [COS_W-1:0]        req_cos,
   input  logic [WAYS-1:0]         req_match,
   input  logic [WAYS-1:0]         line_vld,
   output logic                    hit,
   output logic [$clog2(WAYS)-1:0] hit_way,
   output logic                    inval,
   output logic [$clog2(WAYS)-1:0] inval_way,
   output logic                    fill,
   output logic [$clog2(WAYS)-1:0] fill_way,
   output logic                    no_alloc
);
   import cap_pkg::*;

   localparam int WIDX = $clog2(WAYS);

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("cap_alloc_ctrl: WAYS must be a power of two of at least 2");
   end
   if (COS_W != 2) begin : g_bad_cos
      $error("cap_alloc_ctrl: the class tag must be 2 bits wide");
   end

   acc_kind_e       kind;
   logic [WAYS-1:0] cls_mask;
   logic [WAYS-1:0] vmatch;
   logic [WAYS-1:0] free_elig;
   logic            any_match;
   logic [WIDX-1:0] match_idx;
   logic            any_free;
   logic [WIDX-1:0] free_idx;
   logic [WIDX-1:0] repl_idx;
   logic            is_rw;
   logic            is_flush;
   logic            miss;
   logic            touch_en;
   logic [WIDX-1:0] touch_way;

   assign kind = acc_kind_e'(req_kind);

   cap_mask_regs #(.WAYS(WAYS), .COS_W(COS_W)) u_masks (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_cos  (cfg_cos),
      .wr_mask (cfg_mask),
      .rd_cos  (req_cos),
      .rd_mask (cls_mask)
   );

   // Lookup ignores the class mask entirely.
   assign vmatch = req_match & line_vld;

   cap_prio_enc #(.N(WAYS)) u_match_enc (
      .vec (vmatch),
      .any (any_match),
      .idx (match_idx)
   );

   // Allocation honours the mask: invalid enabled ways first.
   assign free_elig = cls_mask & ~line_vld;

   cap_prio_enc #(.N(WAYS)) u_free_enc (
      .vec (free_elig),
      .any (any_free),
      .idx (free_idx)
   );

   assign is_rw    = req_valid && (kind == ACC_READ || kind == ACC_WRITE);
   assign is_flush = req_valid && (kind == ACC_FLUSH);
   assign miss     = is_rw && !any_match;

   assign hit       = is_rw && any_match;
   assign hit_way   = match_idx;
   assign inval     = is_flush && any_match;
   assign inval_way = match_idx;
   assign no_alloc  = miss && (cls_mask == '0);
   assign fill      = miss && (cls_mask != '0);
   assign fill_way  = any_free ? free_idx : repl_idx;

   assign touch_en  = hit || fill;
   assign touch_way = hit ? match_idx : fill_way;

   if (PLRU_EN) begin : g_plru
      cap_plru #(.WAYS(WAYS)) u_plru (
         .clk       (clk),
         .rst_n     (rst_n),
         .elig      (cls_mask),
         .pick      (repl_idx),
         .touch_en  (touch_en),
         .touch_way (touch_way)
      );
   end else begin : g_fixed
      logic fixed_any;
      cap_prio_enc #(.N(WAYS)) u_fixed_enc (
         .vec (cls_mask),
         .any (fixed_any),
         .idx (repl_idx)
      );
   end
endmodule

// File: rtl/cap_alloc_chk.sv
module cap_alloc_chk #(
   parameter int WAYS    = 16,
   parameter int COS_W   = 2,
   parameter bit PLRU_EN = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_we,
   input logic [COS_W-1:0]        cfg_cos,
   input logic [WAYS-1:0]         cfg_mask,
   input logic                    req_valid,
   input logic [1:0]              req_kind,
   input logic [COS_W-1:0]        req_cos,
   input logic [WAYS-1:0]         req_match,
   input logic [WAYS-1:0]         line_vld,
   input logic                    hit,
   input logic [$clog2(WAYS)-1:0] hit_way,
   input logic                    inval,
   input logic [$clog2(WAYS)-1:0] inval_way,
   input logic                    fill,
   input logic [$clog2(WAYS)-1:0] fill_way,
   input logic                    no_alloc
);
   localparam int NCOS = 1 << COS_W;

   logic [WAYS-1:0] shadow [NCOS];
   logic [WAYS-1:0] cur_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCOS; c++) shadow[c] <= '1;
      end else if (cfg_we) begin
         shadow[cfg_cos] <= cfg_mask;
      end
   end

   assign cur_mask = shadow[req_cos];

   AST_FILL_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      fill |-> cur_mask[fill_way]);                                     // R4
   AST_FILL_PREFERS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (fill && |(cur_mask & ~line_vld)) |-> !line_vld[fill_way]);       // R5
   AST_BYPASS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      no_alloc |-> (cur_mask == '0 && req_valid && req_kind < 2'd2));   // R7
   AST_HIT_REAL: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (req_match[hit_way] && line_vld[hit_way] && req_kind < 2'd2)); // R3
   AST_INVAL_REAL: assert property (@(posedge clk) disable iff (!rst_n)
      inval |-> (req_match[inval_way] && line_vld[inval_way] && req_kind == 2'd2)); // R8
   AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit, inval, fill, no_alloc}));                          // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !(hit || inval || fill || no_alloc));              // R9
endmodule

bind cap_alloc_ctrl cap_alloc_chk #(.WAYS(WAYS), .COS_W(COS_W), .PLRU_EN(PLRU_EN)) u_chk (.*);

// File: tb/tb_cap_alloc_ctrl.sv
`timescale 1ns/1ps
module tb_cap_alloc_ctrl;
   localparam int NW = 4;
   localparam int CW = 2;
   localparam int K_RD = 0;
   localparam int K_WR = 1;
   localparam int K_FL = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [CW-1:0] cfg_cos = '0;
   logic [NW-1:0] cfg_mask = '0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = '0;
   logic [CW-1:0] req_cos = '0;
   logic [NW-1:0] req_match = '0;
   logic [NW-1:0] line_vld = '0;
   logic          hit, inval, fill, no_alloc;
   logic [1:0]    hit_way, inval_way, fill_way;

   int n_chk = 0;
   int n_fail = 0;

   logic [NW-1:0] mdl_mask [4];
   logic [NW-1:1] mdl_tree;

   always #2.5 clk = ~clk;

   cap_alloc_ctrl #(.WAYS(NW), .COS_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cos(cfg_cos),
      .cfg_mask(cfg_mask), .req_valid(req_valid), .req_kind(req_kind),
      .req_cos(req_cos), .req_match(req_match), .line_vld(line_vld),
      .hit(hit), .hit_way(hit_way), .inval(inval), .inval_way(inval_way),
      .fill(fill), .fill_way(fill_way), .no_alloc(no_alloc)
   );

   task automatic chk(input string r, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
      end
   endtask

   function automatic int lowest(input logic [NW-1:0] v);
      for (int i = 0; i < NW; i++) if (v[i]) return i;
      return 0;
   endfunction

   function automatic bit subtree_has(input int node, input logic [NW-1:0] e);
      int lo = node;
      int hi = node;
      while (lo < NW) begin
         lo = lo * 2;
         hi = hi * 2 + 1;
      end
      for (int i = lo; i <= hi; i++) if (e[i-NW]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic int tree_pick(input logic [NW-1:0] e);
      int n = 1;
      while (n < NW) begin
         int c = mdl_tree[n] ? 2*n + 1 : 2*n;
         if (!subtree_has(c, e)) c = c ^ 1;
         n = c;
      end
      return n - NW;
   endfunction

   task automatic tree_touch(input int w);
      int n = NW + w;
      while (n > 1) begin
         int p = n / 2;
         mdl_tree[p] = (n % 2 == 0);
         n = p;
      end
   endtask

   // One cycle: optional request and optional mask write, checked before the edge.
   task automatic acc(input bit rv, input int kind, input int cos,
                      input logic [NW-1:0] mt, input logic [NW-1:0] vl,
                      input bit we, input int wc, input logic [NW-1:0] wm,
                      input string r);
      bit rw, anym, e_hit, e_inv, e_fill, e_na;
      int mi, fw;
      logic [NW-1:0] m;
      @(negedge clk);
      req_valid = rv; req_kind = 2'(kind); req_cos = 2'(cos);
      req_match = mt; line_vld = vl;
      cfg_we = we; cfg_cos = 2'(wc); cfg_mask = wm;
      #1;
      m      = mdl_mask[cos];
      rw     = rv && (kind == K_RD || kind == K_WR);
      anym   = |(mt & vl);
      mi     = lowest(mt & vl);
      e_hit  = rw && anym;
      e_inv  = rv && kind == K_FL && anym;
      e_na   = rw && !anym && m == '0;
      e_fill = rw && !anym && m != '0;
      fw     = (|(m & ~vl)) ? lowest(m & ~vl) : tree_pick(m);
      chk(r, "hit", int'(hit), int'(e_hit));
      chk(r, "inval", int'(inval), int'(e_inv));
      chk(r, "fill", int'(fill), int'(e_fill));
      chk(r, "no_alloc", int'(no_alloc), int'(e_na));
      if (e_hit)  chk(r, "hit_way", int'(hit_way), mi);
      if (e_inv)  chk(r, "inval_way", int'(inval_way), mi);
      if (e_fill) chk(r, "fill_way", int'(fill_way), fw);
      if (e_hit)  tree_touch(mi);
      if (e_fill) tree_touch(fw);
      if (we) mdl_mask[wc] = wm;
      @(posedge clk);
      #0.5;
      req_valid = 1'b0;
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < 4; c++) mdl_mask[c] = '1;
      mdl_tree = '0;
      repeat (3) @(posedge clk);
      #0.5 rst_n = 1'b1;

      // R9: idle cycle with a live match vector produces nothing
      acc(1'b0, K_RD, 0, 4'b1111, 4'b1111, 1'b0, 0, '0, "R9");

      // R1 R6: reset masks all ones, full set, tree walk from all-zero state
      for (int c = 0; c < 4; c++)
         acc(1'b1, K_RD, c, 4'b0000, 4'b1111, 1'b0, 0, '0, "R1_R6");

      // R3: hits regardless of an empty mask, lowest way on multiple matches
      acc(1'b0, K_RD, 0, '0, '0, 1'b1, 1, 4'b0000, "R2");
      acc(1'b1, K_RD, 1, 4'b0100, 4'b1111, 1'b0, 0, '0, "R3");
      acc(1'b1, K_WR, 1, 4'b1010, 4'b1111, 1'b0, 0, '0, "R3");
      // R3 R7: match on an invalid way is a miss; empty mask bypasses
      acc(1'b1, K_RD, 1, 4'b0001, 4'b1110, 1'b0, 0, '0, "R3_R7");
      // R8: flush with an empty mask still invalidates; flush miss is silent
      acc(1'b1, K_FL, 1, 4'b1000, 4'b1000, 1'b0, 0, '0, "R8");
      acc(1'b1, K_FL, 1, 4'b0110, 4'b0110, 1'b0, 0, '0, "R8");
      acc(1'b1, K_FL, 1, 4'b0000, 4'b1111, 1'b0, 0, '0, "R8");
      acc(1'b1, K_FL, 0, 4'b0001, 4'b0000, 1'b0, 0, '0, "R8");
      // kind 3 is ignored
      acc(1'b1, 3, 0, 4'b0001, 4'b1111, 1'b0, 0, '0, "R9");

      // R2: write and miss in the same cycle use the old mask, next cycle the new one
      acc(1'b1, K_RD, 2, 4'b0000, 4'b1111, 1'b1, 2, 4'b0000, "R2");
      acc(1'b1, K_RD, 2, 4'b0000, 4'b1111, 1'b0, 0, '0, "R2");
      acc(1'b1, K_WR, 3, 4'b0000, 4'b1111, 1'b0, 0, '0, "R2");

      // R4 R5 R6 R7: every mask against every valid pattern for every class
      for (int c = 0; c < 4; c++) begin
         for (int m = 0; m < 16; m++) begin
            acc(1'b0, K_RD, c, '0, '0, 1'b1, c, 4'(m), "R2");
            for (int v = 0; v < 16; v++) begin
               acc(1'b1, (v % 2 == 0) ? K_RD : K_WR, c, 4'b0000, 4'(v),
                   1'b0, 0, '0, "R4_R5_R6_R7");
               if (v != 0)
                  acc(1'b1, K_WR, c, 4'(v), 4'(v), 1'b0, 0, '0, "R3");
            end
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule